// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block sets the length of each bus access made to one of eight address areas. A requester hands over one access at a time on a valid/ready request port. The request carries the area number, a direction flag and a flag that marks the target as on-chip. The block then counts bus states until the access is done. The number of states depends on several things:

- whether the target is on-chip;
- the area and the direction;
- the per-area wait-control bits;
- the write-wait bit for area 1;
- the long-wait setting;
- two mode straps. One declares area 1 as DRAM and the other declares area 6 as multiplexed I/O.

Where the access type allows it, the active-low external wait input stretches the access one state at a time.

Handshake rules:

- `req_ready` is high exactly when the block is idle.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- While `req_ready` is low, the requester must hold `req_valid` and the request fields steady.
- The configuration inputs are sampled at acceptance only.
- The cycle after acceptance is state 1 of the access.
- `busy` stays high from state 1 through the final state.
- `cyc_end` pulses for one clock in the final state.
- Because `req_ready` returns only after `busy` falls, back-to-back accesses are two clocks apart at the closest.

Top module: `bus_wait_ctrl`

## Requirements
- R1: An on-chip access to any area other than 5 lasts exactly 1 state, whatever `ext_wait_n` does.
- R2: An on-chip access to area 5 (peripheral space) lasts exactly 3 states, whatever `ext_wait_n` does.
- R3: With `muxio_mode`=1, an external access to area 6 has 4 base states and samples wait, whatever the wait-control bits are.
- R4: An external read of area 1, 3, 4, 5 or 7 (area 1 only with `dram_mode`=0) depends on that area's bit of `area_wait_en`. When the bit is 0, the read lasts 1 state and ignores wait. When the bit is 1, it has 2 base states and samples wait.
- R5: Areas 0, 2 and 6 (area 6 only with `muxio_mode`=0) are long-wait areas. An external read there has 1 base state plus L long-wait states, where L = `long_wait_sel`+1 (encoding 0..3 gives 1..4). Wait is sampled only when the area's `area_wait_en` bit is 1.
- R6: With `dram_mode`=1, an external access to area 1 in either direction depends on `area_wait_en[1]`. When that bit is 0, the access lasts 1 state and ignores wait. When it is 1, it has 2 base states and samples wait.
- R7: An external write to area 3, 4, 5 or 7 has 2 base states and samples wait. An external write to a long-wait area has 1+L base states and samples wait, whatever the wait-control bits are.
- R8: An external write to area 1 with `dram_mode`=0 has 2 base states and samples wait. If `area1_write_wait`=0, `cfg_err` is high during every state of that access. Otherwise `cfg_err` stays low.
- R9: When wait is sampled, the access ends in the first state, at or after the last base state, where `ext_wait_n` is high. So with wait low during states 1..k, the length is max(base, k+1).
- R10: `req_ready` equals not `busy`. An accepted request makes `busy` high in the next cycle. `busy` falls right after the final state.
- R11: `cyc_end` is high for exactly one clock per access, in its final state, and never while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when valid is also high |
| req_area | input | 3 | Target area number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_onchip | input | 1 | 1 = on-chip target |
| area_wait_en | input | 8 | Wait-control bit per area |
| area1_write_wait | input | 1 | Write-wait bit for area 1 |
| long_wait_sel | input | 2 | Long-wait count minus one |
| dram_mode | input | 1 | Area 1 is DRAM |
| muxio_mode | input | 1 | Area 6 is multiplexed I/O |
| ext_wait_n | input | 1 | Active-low wait request |
| busy | output | 1 | Access in progress |
| cyc_end | output | 1 | Final state of the access |
| cfg_err | output | 1 | Illegal write-wait setting for this access |

## Verification
The assertions check the protocol on every cycle:

- `cyc_end` is a single pulse inside `busy`;
- `busy` falls right after `cyc_end` and never before;
- acceptance starts `busy`;
- `cfg_err` is steady during an access and shows only while busy;
- an on-chip non-peripheral access ends in state 1.

The per-area state counts, the long-wait lengths, which access types ignore wait, and the extension rule of R9 depend on the configuration latched at acceptance. Only the bench's scenarios show these, using a reference model that tracks every clock.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic [CNT_W-1:0] extra;   // base states minus one
    logic             sample;  // wait input honoured
    logic             err;     // illegal setting seen
  } timing_t;
endpackage

// File: rtl/bwc_classify.sv
module bwc_classify
  import bwc_pkg::*;
#(
  parameter int          N_AREAS       = 8,
  parameter int          AREA_W        = $clog2(N_AREAS),
  parameter int          LW_W          = 2,
  parameter logic [7:0]  LW_AREA_MASK  = 8'b0100_0101,
  parameter int          DRAM_AREA     = 1,
  parameter int          MUXIO_AREA    = 6,
  parameter int          PERIPH_AREA   = 5,
  parameter int          PERIPH_STATES = 3,
  parameter int          MUXIO_STATES  = 4
) (
  input  logic [AREA_W-1:0]  area,
  input  logic               write,
  input  logic               onchip,
  input  logic [N_AREAS-1:0] wait_en,
  input  logic               write_wait,
  input  logic [LW_W-1:0]    lw_sel,
  input  logic               dram_mode,
  input  logic               muxio_mode,
  output timing_t            timing
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lw_len;
  logic             is_lw, is_dram, is_mux, is_periph, bit_set;

  assign lw_len    = CNT_W'(lw_sel) + ONE;
  assign is_lw     = LW_AREA_MASK[area];
  assign is_dram   = (area == AREA_W'(DRAM_AREA)) && dram_mode;
  assign is_mux    = (area == AREA_W'(MUXIO_AREA)) && muxio_mode;
  assign is_periph = (area == AREA_W'(PERIPH_AREA));
  assign bit_set   = wait_en[area];

  always_comb begin
    timing = '0;
    if (onchip) begin
      timing.extra = is_periph ? CNT_W'(PERIPH_STATES - 1) : '0;
    end else if (is_mux) begin
      timing.extra  = CNT_W'(MUXIO_STATES - 1);
      timing.sample = 1'b1;
    end else if (is_dram) begin
      timing.extra  = bit_set ? ONE : '0;
      timing.sample = bit_set;
    end else if (is_lw) begin
      timing.extra  = lw_len;
      timing.sample = write | bit_set;
    end else if (write) begin
      timing.extra  = ONE;
      timing.sample = 1'b1;
      timing.err    = (area == AREA_W'(DRAM_AREA)) && !write_wait;
    end else begin
      timing.extra  = bit_set ? ONE : '0;
      timing.sample = bit_set;
    end
  end
endmodule

// File: rtl/bwc_sequencer.sv
module bwc_sequencer
  import bwc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  timing_t timing,
  input  logic    wait_n,
  output logic    busy,
  output logic    last,
  output logic    err
);
  logic [CNT_W-1:0] left_q;
  logic             samp_q;

  assign last = busy && (left_q == '0) && (!samp_q || wait_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
      samp_q <= 1'b0;
      err    <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= timing.extra;
      samp_q <= timing.sample;
      err    <= timing.err;
    end else if (busy) begin
      if (left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
      end else if (last) begin
        busy <= 1'b0;
        err  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int          N_AREAS      = 8,
  parameter int          AREA_W       = $clog2(N_AREAS),
  parameter int          LW_W         = 2,
  parameter logic [7:0]  LW_AREA_MASK = 8'b0100_0101,
  parameter int          PERIPH_AREA  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AREA_W-1:0]  req_area,
  input  logic               req_write,
  input  logic               req_onchip,
  input  logic [N_AREAS-1:0] area_wait_en,
  input  logic               area1_write_wait,
  input  logic [LW_W-1:0]    long_wait_sel,
  input  logic               dram_mode,
  input  logic               muxio_mode,
  input  logic               ext_wait_n,
  output logic               busy,
  output logic               cyc_end,
  output logic               cfg_err
);
  timing_t tm;
  logic    start;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  bwc_classify #(
    .N_AREAS(N_AREAS), .AREA_W(AREA_W), .LW_W(LW_W),
    .LW_AREA_MASK(LW_AREA_MASK), .PERIPH_AREA(PERIPH_AREA)
  ) cls_i (
    .area(req_area), .write(req_write), .onchip(req_onchip),
    .wait_en(area_wait_en), .write_wait(area1_write_wait),
    .lw_sel(long_wait_sel), .dram_mode(dram_mode),
    .muxio_mode(muxio_mode), .timing(tm)
  );

  bwc_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .timing(tm),
    .wait_n(ext_wait_n), .busy(busy), .last(cyc_end), .err(cfg_err)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int AREA_W      = 3,
  parameter int PERIPH_AREA = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AREA_W-1:0] req_area,
  input logic              req_onchip,
  input logic              busy,
  input logic              cyc_end,
  input logic              cfg_err
);
  AST_END_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> busy);  // R11
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !cyc_end);  // R11
  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !busy);  // R10
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_end) |=> busy);  // R10
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);  // R10
  AST_ERR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> busy);  // R8
  AST_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_end) |=> $stable(cfg_err));  // R8
  AST_ONCHIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_onchip && req_area != AREA_W'(PERIPH_AREA))
      |=> cyc_end);  // R1
endmodule

bind bus_wait_ctrl bwc_checker #(.AREA_W(AREA_W), .PERIPH_AREA(PERIPH_AREA)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_area(req_area), .req_onchip(req_onchip), .busy(busy),
  .cyc_end(cyc_end), .cfg_err(cfg_err)
);

// File: tb/bus_wait_ctrl_tb_top.sv
module bus_wait_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_area = '0;
  logic       req_write = 1'b0;
  logic       req_onchip = 1'b0;
  logic [7:0] area_wait_en = '0;
  logic       area1_write_wait = 1'b1;
  logic [1:0] long_wait_sel = '0;
  logic       dram_mode = 1'b0;
  logic       muxio_mode = 1'b0;
  logic       ext_wait_n = 1'b1;
  logic       busy, cyc_end, cfg_err;

  int errors = 0;
  int checks = 0;
  string tag = "R10";

  always #10 clk = ~clk;  // 50 MHz

  bus_wait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_write(req_write), .req_onchip(req_onchip),
    .area_wait_en(area_wait_en), .area1_write_wait(area1_write_wait),
    .long_wait_sel(long_wait_sel), .dram_mode(dram_mode),
    .muxio_mode(muxio_mode), .ext_wait_n(ext_wait_n), .busy(busy),
    .cyc_end(cyc_end), .cfg_err(cfg_err)
  );

  // Expected timing, written from the requirement text
  function automatic void expect_of(input int a, input bit wr, input bit onc,
                                    output int base, output bit samp, output bit err);
    bit lw_area;
    lw_area = (a == 0) || (a == 2) || (a == 6 && !muxio_mode);
    err = 1'b0;
    if (onc) begin                                   // R1 / R2
      base = (a == 5) ? 3 : 1; samp = 1'b0;
    end else if (a == 6 && muxio_mode) begin         // R3
      base = 4; samp = 1'b1;
    end else if (a == 1 && dram_mode) begin          // R6
      samp = area_wait_en[1]; base = samp ? 2 : 1;
    end else if (lw_area) begin                      // R5 / R7
      base = 2 + int'(long_wait_sel); samp = wr || area_wait_en[a];
    end else if (wr) begin                           // R7 / R8
      base = 2; samp = 1'b1; err = (a == 1) && !area1_write_wait;
    end else begin                                   // R4
      samp = area_wait_en[a]; base = samp ? 2 : 1;
    end
  endfunction

  // Reference model, advanced on every rising edge
  bit m_busy = 1'b0;
  int m_left = 0;
  bit m_samp = 1'b0;
  bit m_err  = 1'b0;

  function automatic bit m_end();
    return m_busy && (m_left == 1) && (!m_samp || ext_wait_n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_left = 0; m_samp = 1'b0; m_err = 1'b0;
    end else if (!m_busy) begin
      if (req_valid) begin
        int b; bit s; bit e;
        expect_of(int'(req_area), req_write, req_onchip, b, s, e);
        m_busy = 1'b1; m_left = b; m_samp = s; m_err = e;
      end
    end else if (m_left > 1) begin
      m_left--;
    end else if (m_end()) begin
      m_busy = 1'b0; m_err = 1'b0;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (busy !== m_busy || req_ready !== !m_busy || cyc_end !== m_end() || cfg_err !== m_err) begin
      errors++;
      $display("FAIL %s cycle compare: busy/ready/end/err=%b%b%b%b expected %b%b%b%b",
               tag, busy, req_ready, cyc_end, cfg_err, m_busy, !m_busy, m_end(), m_err);
    end
  end

  // One access with wait held low for states 1..k, then length check
  task automatic access(input string t, input int a, input bit wr, input bit onc, input int k);
    int base; bit samp; bit err; int exp_len; int len; bit err_seen;
    tag = t;
    @(posedge clk); #1;
    req_area = 3'(a); req_write = wr; req_onchip = onc; req_valid = 1'b1;
    ext_wait_n = (k >= 1) ? 1'b0 : 1'b1;
    expect_of(a, wr, onc, base, samp, err);
    exp_len = samp ? ((k + 1 > base) ? k + 1 : base) : base;
    @(posedge clk); #1;
    req_valid = 1'b0;
    len = 0; err_seen = 1'b0;
    for (int s = 1; s < 40; s++) begin
      ext_wait_n = (s <= k) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (s == 1) err_seen = cfg_err;
      if (cyc_end) begin len = s; break; end
      @(posedge clk); #1;
    end
    checks++;
    if (len != exp_len) begin
      errors++;
      $display("FAIL %s length area %0d wr %0d k %0d: got %0d expected %0d", t, a, wr, k, len, exp_len);
    end
    checks++;
    if (err_seen !== err) begin
      errors++;
      $display("FAIL %s cfg_err: got %b expected %b", t, err_seen, err);
    end
    @(posedge clk); #1;
    ext_wait_n = 1'b1;
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;                       // reset state compared per cycle (R10)
    access("R1", 0, 0, 1, 3);
    access("R1", 7, 1, 1, 2);
    access("R2", 5, 0, 1, 4);
    muxio_mode = 1'b1;
    access("R3", 6, 0, 0, 0);
    access("R3", 6, 1, 0, 6);
    muxio_mode = 1'b0;
    access("R4", 3, 0, 0, 3);
    area_wait_en = 8'b0001_1000;
    access("R4", 3, 0, 0, 0);
    access("R9", 4, 0, 0, 4);
    long_wait_sel = 2'd3; area_wait_en = 8'b0000_0100;
    access("R5", 2, 0, 0, 0);
    access("R9", 2, 0, 0, 7);
    area_wait_en = 8'b0000_0000;
    access("R5", 2, 0, 0, 7);
    long_wait_sel = 2'd0;
    access("R5", 0, 0, 0, 2);
    dram_mode = 1'b1;
    access("R6", 1, 0, 0, 3);
    access("R6", 1, 1, 0, 3);
    area_wait_en = 8'b0000_0010;
    access("R6", 1, 0, 0, 3);
    access("R6", 1, 1, 0, 0);
    dram_mode = 1'b0; area_wait_en = '0;
    access("R7", 4, 1, 0, 0);
    access("R7", 7, 1, 0, 3);
    long_wait_sel = 2'd1;
    access("R7", 6, 1, 0, 0);
    access("R9", 6, 1, 0, 5);
    area1_write_wait = 1'b0;
    access("R8", 1, 1, 0, 0);
    area1_write_wait = 1'b1;
    access("R8", 1, 1, 0, 2);
    // Held request: back-to-back acceptance follows ready (R10, R11)
    tag = "R10";
    @(posedge clk); #1;
    req_area = 3'd5; req_onchip = 1'b1; req_write = 1'b0; req_valid = 1'b1;
    repeat (12) @(posedge clk);
    #1 req_valid = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: got hang expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule